// File: doc/BRIEF.md
# Rotation Angle Folding Front End

This block is the argument-reduction stage in front of a unidirectional, scale-free rotation pipeline. It takes a signed target angle in radians and a vector sample. It reduces the angle in two steps. First it removes whole quarter turns, which leaves a residual angle between zero and a right angle. Then it places that residual in one of four equal eighth-pi bands and folds it into a small angle between zero and pi/8. Depending on the band, the fold is a mirror about a band edge or a shift by pi/4.

The rotation core downstream only ever turns by the small folded angle. The band decides whether that turn is positive or negative. The quarter-turn count and the band code travel with the sample, so a later output stage can rebuild the full rotation. The unit has one register stage and a single valid strobe. Each cycle it accepts one sample, and the result appears one clock later.

The angle input uses three integer bits and 13 fraction bits, so 1.0 is 8192. The folded angle leaves on a 13-bit unsigned word with 14 fraction bits, so 1.0 is 16384 and pi/8 is 0x1922. Inputs are expected to lie in [-25736, 25735], which is [-pi, pi).

Top module: `angle_fold_unit`

## Requirements
- R1: While rst_ni is low, valid_o, quad_o, seg_o, dir_o, phi_o, x_o and y_o are all zero.
- R2: valid_o equals valid_i one clock earlier, so each accepted sample produces exactly one result, in order, one cycle later.
- R3: The quarter-turn code quad_o is 0 for 0 <= angle <= 12868, 1 for angle > 12868, 2 for angle < -12868, and 3 for -12868 <= angle < 0. The residual angle is the input minus quad_o*12868, taken modulo 51472.
- R4: The band code seg_o is taken from the residual r. It is 0 for r <= 3217, 1 for 3217 < r <= 6434, 2 for 6434 < r <= 9651, and 3 above that. A value exactly on a band edge belongs to the lower band.
- R5: Let f be the folded angle in input units. f is r in band 0, 6434 - r in band 1, r - 6434 in band 2, and 12868 - r in band 3. phi_o is 2*f, so bit 0 of phi_o is always 0.
- R6: phi_o never exceeds 0x1922. An input of exactly 3217 (pi/8) gives phi_o = 0x1922.
- R7: dir_o is 1 (rotate by +phi) for bands 1 and 3, and 0 (rotate by -phi) for bands 0 and 2.
- R8: x_o and y_o carry x_i and y_i unchanged, in the same cycle as the codes and the folded angle computed from the same sample.
- R9: When valid_i is low, the payload outputs (quad_o, seg_o, dir_o, phi_o, x_o, y_o) keep their previous values, whatever is on the data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| angle_i | input | 16 | Target angle, two's complement, 13 fraction bits |
| x_i | input | 16 | Vector x component |
| y_i | input | 16 | Vector y component |
| valid_o | output | 1 | Result strobe |
| quad_o | output | 2 | Quarter turns removed (0..3, counter-clockwise) |
| seg_o | output | 2 | Eighth-pi band of the residual angle |
| dir_o | output | 1 | 1: rotate by +phi, 0: rotate by -phi |
| phi_o | output | 13 | Folded angle, unsigned, 14 fraction bits |
| x_o | output | 16 | Registered x component |
| y_o | output | 16 | Registered y component |

## Verification
All state sits in one register rank, so any wrong internal value is visible at the ports one cycle after the sample that caused it. A mistake in band selection or in a fold rule usually shows as a phi_o above 0x1922 or as a dir_o that disagrees with seg_o. Values on the band edges and the quarter-turn edges test the tie rule directly. A wrong quarter reduction gives a folded angle that is plausible but wrong, so the bench checks every field against a model over a sweep of the whole input range.

// File: rtl/fold_pkg.sv
package fold_pkg;

  typedef enum logic [1:0] {
    QTR_0   = 2'd0,
    QTR_90  = 2'd1,
    QTR_180 = 2'd2,
    QTR_270 = 2'd3
  } qtr_e;

  typedef enum logic [1:0] {
    SEG_DIRECT = 2'd0,
    SEG_MIRLO  = 2'd1,
    SEG_SHIFT  = 2'd2,
    SEG_MIRHI  = 2'd3
  } seg_e;

  // Integer multiple of pi/8 at a given number of fraction bits.
  function automatic int pi_eighths(int frac_w, int n);
    real one_eighth;
    one_eighth = 0.39269908169872414 * (2.0 ** frac_w);
    return n * int'(one_eighth);
  endfunction

endpackage

// File: rtl/quadrant_reducer.sv
module quadrant_reducer
  import fold_pkg::*;
#(
  parameter int ANGLE_W = 16,
  parameter int FRAC_W  = 13
) (
  input  logic [ANGLE_W-1:0] angle_i,
  output qtr_e               qtr_o,
  output logic [ANGLE_W-1:0] resid_o
);

  localparam int HALF_PI = pi_eighths(FRAC_W, 4);
  localparam int FULL_PI = pi_eighths(FRAC_W, 8);

  int th;
  int r;

  always_comb begin
    th = int'($signed(angle_i));
    if (th >= 0 && th <= HALF_PI) begin
      qtr_o = QTR_0;
      r     = th;
    end else if (th > HALF_PI) begin
      qtr_o = QTR_90;
      r     = th - HALF_PI;
    end else if (th < -HALF_PI) begin
      qtr_o = QTR_180;
      r     = th + FULL_PI;
    end else begin
      qtr_o = QTR_270;
      r     = th + HALF_PI;
    end
    resid_o = ANGLE_W'(r);
  end

endmodule

// File: rtl/domain_folder.sv
module domain_folder
  import fold_pkg::*;
#(
  parameter int ANGLE_W    = 16,
  parameter int FRAC_W     = 13,
  parameter int OUT_FRAC_W = 14,
  parameter int PHI_W      = 13
) (
  input  logic [ANGLE_W-1:0] resid_i,
  output seg_e               seg_o,
  output logic [PHI_W-1:0]   phi_o
);

  localparam int E1    = pi_eighths(FRAC_W, 1);
  localparam int E2    = pi_eighths(FRAC_W, 2);
  localparam int E3    = pi_eighths(FRAC_W, 3);
  localparam int E4    = pi_eighths(FRAC_W, 4);
  localparam int SHIFT = OUT_FRAC_W - FRAC_W;

  int a;
  int f;

  always_comb begin
    a = int'(resid_i);
    // band edges resolve to the lower band
    if (a <= E1) begin
      seg_o = SEG_DIRECT;
      f     = a;
    end else if (a <= E2) begin
      seg_o = SEG_MIRLO;
      f     = E2 - a;
    end else if (a <= E3) begin
      seg_o = SEG_SHIFT;
      f     = a - E2;
    end else begin
      seg_o = SEG_MIRHI;
      f     = E4 - a;
    end
    phi_o = PHI_W'(f << SHIFT);
  end

endmodule

// File: rtl/dir_select.sv
module dir_select
  import fold_pkg::*;
(
  input  seg_e seg_i,
  output logic pos_o
);

  always_comb begin
    unique case (seg_i)
      SEG_MIRLO, SEG_MIRHI: pos_o = 1'b1;
      default:              pos_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/angle_fold_unit.sv
module angle_fold_unit
  import fold_pkg::*;
#(
  parameter int ANGLE_W    = 16,
  parameter int FRAC_W     = 13,
  parameter int OUT_FRAC_W = 14,
  parameter int PHI_W      = 13,
  parameter int DATA_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic [DATA_W-1:0]  x_i,
  input  logic [DATA_W-1:0]  y_i,
  output logic               valid_o,
  output logic [1:0]         quad_o,
  output logic [1:0]         seg_o,
  output logic               dir_o,
  output logic [PHI_W-1:0]   phi_o,
  output logic [DATA_W-1:0]  x_o,
  output logic [DATA_W-1:0]  y_o
);

  qtr_e               qtr_c;
  seg_e               seg_c;
  logic [ANGLE_W-1:0] resid_c;
  logic [PHI_W-1:0]   phi_c;
  logic               pos_c;

  quadrant_reducer #(
    .ANGLE_W(ANGLE_W),
    .FRAC_W (FRAC_W)
  ) u_qtr (
    .angle_i(angle_i),
    .qtr_o  (qtr_c),
    .resid_o(resid_c)
  );

  domain_folder #(
    .ANGLE_W   (ANGLE_W),
    .FRAC_W    (FRAC_W),
    .OUT_FRAC_W(OUT_FRAC_W),
    .PHI_W     (PHI_W)
  ) u_fold (
    .resid_i(resid_c),
    .seg_o  (seg_c),
    .phi_o  (phi_c)
  );

  dir_select u_dir (
    .seg_i(seg_c),
    .pos_o(pos_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      quad_o  <= '0;
      seg_o   <= '0;
      dir_o   <= 1'b0;
      phi_o   <= '0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        quad_o <= qtr_c;
        seg_o  <= seg_c;
        dir_o  <= pos_c;
        phi_o  <= phi_c;
        x_o    <= x_i;
        y_o    <= y_i;
      end
    end
  end

endmodule

// File: rtl/fold_checker.sv
module fold_checker
  import fold_pkg::*;
#(
  parameter int ANGLE_W    = 16,
  parameter int FRAC_W     = 13,
  parameter int OUT_FRAC_W = 14,
  parameter int PHI_W      = 13,
  parameter int DATA_W     = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [ANGLE_W-1:0] angle_i,
  input logic [DATA_W-1:0]  x_i,
  input logic [DATA_W-1:0]  y_i,
  input logic               valid_o,
  input logic [1:0]         quad_o,
  input logic [1:0]         seg_o,
  input logic               dir_o,
  input logic [PHI_W-1:0]   phi_o,
  input logic [DATA_W-1:0]  x_o,
  input logic [DATA_W-1:0]  y_o
);

  localparam int PHI_MAX = pi_eighths(FRAC_W, 1) << (OUT_FRAC_W - FRAC_W);
  localparam int HALF_PI = pi_eighths(FRAC_W, 4);

  AST_PHI_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(phi_o) <= PHI_MAX)); // R6

  AST_PHI_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (phi_o[0] == 1'b0)); // R5

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2

  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2

  AST_DIR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dir_o == seg_o[0])); // R7

  AST_VEC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (x_o == $past(x_i) && y_o == $past(y_i))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(phi_o) && $stable(quad_o) && $stable(x_o) && $stable(y_o))); // R9

  AST_QTR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && int'($signed(angle_i)) >= 0 && int'($signed(angle_i)) <= HALF_PI)
      |=> (quad_o == 2'd0)); // R3

endmodule

bind angle_fold_unit fold_checker #(
  .ANGLE_W   (ANGLE_W),
  .FRAC_W    (FRAC_W),
  .OUT_FRAC_W(OUT_FRAC_W),
  .PHI_W     (PHI_W),
  .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/sim_angle_fold_unit.sv
module sim_angle_fold_unit;

  localparam int E1 = 3217;
  localparam int E2 = 6434;
  localparam int E3 = 9651;
  localparam int E4 = 12868;
  localparam int E8 = 25736;

  typedef struct {
    int quad;
    int seg;
    int dir;
    int phi;
    int x;
    int y;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] angle_i = '0;
  logic [15:0] x_i = '0;
  logic [15:0] y_i = '0;
  logic        valid_o;
  logic [1:0]  quad_o;
  logic [1:0]  seg_o;
  logic        dir_o;
  logic [12:0] phi_o;
  logic [15:0] x_o;
  logic [15:0] y_o;

  int   errors = 0;
  int   checks = 0;
  int   sent = 0;
  int   seen = 0;
  exp_t sb[$];

  always #5 clk_i = ~clk_i;

  angle_fold_unit u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .angle_i(angle_i),
    .x_i    (x_i),
    .y_i    (y_i),
    .valid_o(valid_o),
    .quad_o (quad_o),
    .seg_o  (seg_o),
    .dir_o  (dir_o),
    .phi_o  (phi_o),
    .x_o    (x_o),
    .y_o    (y_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input int th, input int x, input int y);
    exp_t e;
    int r;
    int f;
    if (th >= 0 && th <= E4) begin e.quad = 0; r = th; end
    else if (th > E4)        begin e.quad = 1; r = th - E4; end
    else if (th < -E4)       begin e.quad = 2; r = th + E8; end
    else                     begin e.quad = 3; r = th + E4; end
    if (r <= E1)      begin e.seg = 0; f = r; end
    else if (r <= E2) begin e.seg = 1; f = E2 - r; end
    else if (r <= E3) begin e.seg = 2; f = r - E2; end
    else              begin e.seg = 3; f = E4 - r; end
    e.dir = (e.seg == 1 || e.seg == 3) ? 1 : 0;
    e.phi = 2 * f;
    e.x = x & 16'hffff;
    e.y = y & 16'hffff;
    return e;
  endfunction

  task automatic send(input int th, input int x, input int y);
    @(negedge clk_i);
    valid_i = 1'b1;
    angle_i = th[15:0];
    x_i     = x[15:0];
    y_i     = y[15:0];
    sb.push_back(model(th, x, y));
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      angle_i = 16'(i * 4111 + 77);
      x_i     = 16'(i * 917);
      y_i     = 16'(i * 313 + 5);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        seen++;
        chk(int'(quad_o) == e.quad, "R3 quad", int'(quad_o), e.quad);
        chk(int'(seg_o) == e.seg, "R4 seg", int'(seg_o), e.seg);
        chk(int'(phi_o) == e.phi, "R5 phi", int'(phi_o), e.phi);
        chk(int'(phi_o) <= 16'h1922, "R6 phi bound", int'(phi_o), 16'h1922);
        chk(int'(dir_o) == e.dir, "R7 dir", int'(dir_o), e.dir);
        chk(int'(x_o) == e.x && int'(y_o) == e.y, "R8 vector",
            int'({x_o, y_o}), (e.x << 16) | e.y);
      end
    end
  end

  initial begin : watchdog
    #(150000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [12:0] hp;
    logic [15:0] hx;
    logic [1:0]  hq;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid_o", int'(valid_o), 0);
    chk(phi_o == '0 && quad_o == '0 && seg_o == '0 && dir_o == 1'b0, "R1 codes",
        int'(phi_o), 0);
    chk(x_o == '0 && y_o == '0, "R1 vector", int'(x_o), 0);
    rst_ni = 1'b1;
    idle(2);

    // R6 pi/8 folds to 0x1922
    send(E1, 11, 22);
    idle(1);
    chk(phi_o == 13'h1922, "R6 pi/8 code", int'(phi_o), 13'h1922);

    // band and quarter edges (R4 lower-band ties, R3 quarter ties)
    send(0, 1, 2);
    send(E1 + 1, 3, 4);
    send(E2, 5, 6);
    send(E2 + 1, 7, 8);
    send(E3, 9, 10);
    send(E3 + 1, 11, 12);
    send(E4, 13, 14);
    send(E4 + 1, 15, 16);
    send(-1, 17, 18);
    send(-E4, 19, 20);
    send(-E4 - 1, 21, 22);
    send(-E8, 23, 24);
    send(E8 - 1, 25, 26);
    send(2859, -100, 100);
    idle(3);

    // sweep the range, back-to-back with occasional gaps (R2)
    for (int k = -E8; k < E8; k += 97) begin
      send(k, k * 3, -k);
      if ((k & 7) == 0) idle(1);
    end
    idle(3);

    // R9 hold while idle with toggling inputs
    send(E3 - 5, 16'h1234, 16'h4321);
    idle(1);
    hp = phi_o;
    hx = x_o;
    hq = quad_o;
    idle(6);
    chk(valid_o == 1'b0, "R9 valid low", int'(valid_o), 0);
    chk(phi_o == hp && x_o == hx && quad_o == hq, "R9 hold",
        int'(phi_o), int'(hp));

    idle(3);
    chk(seen == sent && sb.size() == 0, "R2 result count", seen, sent);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule